// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block drives the two-wire management bus that a station uses to read and write PHY registers. Software places a complete 32-bit management frame, with start, opcode, PHY address, register address, turnaround and data already packed, into a frame register. If the controller is idle and enabled, it then generates the management clock and sends a preamble of 32 one bits followed by the 32 frame bits, most significant bit first.

For a read frame the controller releases the data line for the turnaround and data slots and shifts the 16 bits returned by the PHY into the low half of the same frame register. At the end of every frame it sets a sticky completion event. That event drives the interrupt output and is cleared by writing one to it. The management clock rate comes from a 6-bit divider field in a speed register, chosen so that the clock stays below about 2.5 MHz.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, every register reads zero. `mdc`, `mdio_oe`, `busy` and `irq` are low.
- R2: A write to the frame register (address 0) while idle, with the enable bit set and a nonzero divider, starts a transaction. `busy` is high in the next cycle and stays high until the event sets.
- R3: On the wire the controller sends 32 one bits, then frame bits 31 down to 0. `mdio_o` changes only where `mdc` falls, so each bit is stable at the rising `mdc` edge that follows.
- R4: The divider field is bits [6:1] of the speed register (address 2). `mdc` stays high for exactly divider system clock cycles and low for the same number, so one frame keeps `busy` high for 128 × divider cycles. `mdc` is low whenever the controller is idle.
- R5: A frame whose bits [31:28] equal 0x6 is a read. `mdio_oe` is low for the last 18 bit slots (turnaround and data). The 16 bits sampled on the rising `mdc` edges of the data slots replace frame register bits [15:0], first bit received into bit 15. Bits [31:16] keep their written value.
- R6: Any other value in bits [31:28] is a write. `mdio_oe` is high for all 64 bit slots, and the frame register keeps the value that was written.
- R7: The completion event is bit 23 of the event register (address 1). It sets in the same cycle that `busy` falls, and `irq` follows it.
- R8: Writing 1 to event bit 23 clears the event. Writing 0 to it leaves the event unchanged. A completion in the same cycle as a clearing write leaves the event set.
- R9: A write to the frame register while `busy` is high is ignored. The register readback is unchanged and the bits on the wire are those of the original frame.
- R10: If the enable bit (bit 2 of the control register, address 3) is clear, or the divider is zero, a frame register write stores the value but starts nothing. `busy` and `mdc` stay low.
- R11: Unimplemented register bits read zero. The speed register returns only bits [6:1], the control register only bit 2, and the event register only bit 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 frame, 1 event, 2 speed, 3 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the management data line |
| mdio_i | input | 1 | Management data in |
| busy | output | 1 | A transaction is in progress |
| irq | output | 1 | Completion event, level |

## Verification
On every cycle, the assertions check the following relations. `mdc` is low while idle and the captured divider is nonzero while running. The data line moves only on a falling `mdc`. The line is driven throughout a write and released whenever a read bit is sampled. A start always raises `busy`, `busy` falls only with the event set, and a frame register write during `busy` leaves the register untouched. The bench scenarios cover what needs a whole transaction to show: the exact 64-bit sequence on the wire, the high and low `mdc` cycle counts for several divider values, the returned read data merged into the register, write-one-to-clear behaviour, and transactions suppressed by the enable bit or a zero divider.

// File: rtl/mdio_pkg.sv
// Package: shared constants and types for the management frame controller.
// Assumes a 2-bit register address and a fixed 32-bit management frame.
package mdio_pkg;
    localparam int FRAME_W     = 32;
    localparam int RX_W        = 16;
    localparam int TA_W        = 2;
    localparam int OPN_W       = 4;
    localparam int EVT_BIT     = 23;
    localparam int CTRL_EN_BIT = 2;
    localparam int SPD_LO      = 1;

    localparam logic [1:0] ADDR_DATA  = 2'd0;
    localparam logic [1:0] ADDR_EVT   = 2'd1;
    localparam logic [1:0] ADDR_SPEED = 2'd2;
    localparam logic [1:0] ADDR_CTRL  = 2'd3;

    // Start 01 + opcode 10 in the top nibble marks a read frame.
    localparam logic [OPN_W-1:0] READ_NIBBLE = 4'h6;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_e;
endpackage

// File: rtl/mdio_clkgen.sv
// Module: management clock generator.
// Latches the divider at start. While run is high, it toggles mdc every
// div system clock cycles and flags each rising and falling transition
// one cycle ahead as a tick. Assumes the divider is nonzero when start fires.
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap      = run && (cnt == div_q - 1'b1);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    // Capture the divider for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)     div_q <= '0;
        else if (start) div_q <= div_in;
    end

    // Count system cycles within one half-period of mdc.
    always_ff @(posedge clk) begin
        if (!rst_n || start) cnt <= '0;
        else if (wrap)       cnt <= '0;
        else if (run)        cnt <= cnt + 1'b1;
    end

    // Toggle mdc at each half-period boundary, park it low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     mdc <= 1'b0;
        else if (start) mdc <= 1'b0;
        else if (wrap)  mdc <= ~mdc;
        else if (!run)  mdc <= 1'b0;
    end

    // R4: the management clock rests low whenever no frame is running.
    a_r4_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mdc);

    // R4: a running transaction always has a usable divider.
    a_r4_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_q != '0));
endmodule

// File: rtl/mdio_shifter.sv
// Module: frame serialiser and read-data capture.
// On start it loads the preamble and the frame, shifts one bit out per
// falling tick, releases the line for the turnaround and data of a read,
// and samples the data slots on rising ticks. done pulses on the final fall.
module mdio_shifter #(
    parameter int PRE_LEN = 32,
    parameter int FRAME_W = 32,
    parameter int RX_W    = 16,
    parameter int TA_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_i,
    output logic               run,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done,
    output logic               capture_we,
    output logic [RX_W-1:0]    rx_data
);
    import mdio_pkg::*;

    localparam int TOT   = PRE_LEN + FRAME_W;
    localparam int IDX_W = $clog2(TOT);
    localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(TOT - 1);
    localparam logic [IDX_W-1:0] RELEASE_IDX = IDX_W'(TOT - RX_W - TA_W);
    localparam logic [IDX_W-1:0] RX_IDX      = IDX_W'(TOT - RX_W);

    run_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [TOT-1:0]   shreg;
    logic             is_rd;
    logic [RX_W-1:0]  rx_q;
    logic             released;

    assign run        = (state == ST_RUN);
    assign done       = run && fall_tick && (idx == LAST_IDX);
    assign capture_we = done && is_rd;
    assign released   = is_rd && (idx >= RELEASE_IDX);
    assign mdio_oe    = run && !released;
    assign mdio_o     = run ? shreg[TOT-1] : 1'b1;
    assign rx_data    = rx_q;

    // Sequence the transaction from start to the last falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= ST_IDLE;
        else if (start) state <= ST_RUN;
        else if (done)  state <= ST_IDLE;
    end

    // Track the bit slot and shift the next bit out on each fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            shreg <= '1;
        end else if (start) begin
            idx   <= '0;
            shreg <= {{PRE_LEN{1'b1}}, frame_in};
        end else if (run && fall_tick && !done) begin
            idx   <= idx + 1'b1;
            shreg <= {shreg[TOT-2:0], 1'b1};
        end
    end

    // Remember whether the loaded frame is a read.
    always_ff @(posedge clk) begin
        if (!rst_n)     is_rd <= 1'b0;
        else if (start) is_rd <= (frame_in[FRAME_W-1 -: OPN_W] == READ_NIBBLE);
    end

    // Shift in returned bits on rising edges during the data slots.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_q <= '0;
        else if (run && rise_tick && is_rd && (idx >= RX_IDX))
            rx_q <= {rx_q[RX_W-2:0], mdio_i};
    end

    // R3: the data line moves only at a falling mdc transition.
    a_r3_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(mdio_o)) |-> $past(fall_tick));

    // R5: the line is released whenever a read bit is sampled.
    a_r5_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rise_tick && is_rd && (idx >= RX_IDX)) |-> !mdio_oe);

    // R6: a write frame is driven for every slot.
    a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !is_rd) |-> mdio_oe);

    // R7: the final fall ends the transaction.
    a_r7_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !run);
endmodule

// File: rtl/mdio_regs.sv
// Module: software-visible registers.
// Holds the frame, event, speed and control registers, decides when a
// frame register write launches a transaction, and merges read data back.
// Assumes done and capture_we are single-cycle pulses from the serialiser.
module mdio_regs #(
    parameter int FRAME_W = 32,
    parameter int DIV_W   = 6,
    parameter int RX_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               busy,
    input  logic               done,
    input  logic               capture_we,
    input  logic [RX_W-1:0]    rx_data,
    output logic               start,
    output logic [FRAME_W-1:0] frame,
    output logic [DIV_W-1:0]   div,
    output logic               irq
);
    import mdio_pkg::*;

    logic [FRAME_W-1:0] data_q;
    logic               evt_q;
    logic [DIV_W-1:0]   div_q;
    logic               en_q;
    logic               sel_data;

    assign sel_data = reg_wr && (reg_addr == ADDR_DATA);
    assign start    = sel_data && !busy && en_q && (div_q != '0);
    assign frame    = reg_wdata[FRAME_W-1:0];
    assign div      = div_q;
    assign irq      = evt_q;

    // Frame register: software write when idle, read data merge at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)              data_q <= '0;
        else if (capture_we)     data_q[RX_W-1:0] <= rx_data;
        else if (sel_data && !busy) data_q <= reg_wdata[FRAME_W-1:0];
    end

    // Sticky completion event, set has priority over the write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else if (done) evt_q <= 1'b1;
        else if (reg_wr && (reg_addr == ADDR_EVT) && reg_wdata[EVT_BIT]) evt_q <= 1'b0;
    end

    // Divider field of the speed register.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else if (reg_wr && (reg_addr == ADDR_SPEED)) div_q <= reg_wdata[SPD_LO +: DIV_W];
    end

    // Management enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else if (reg_wr && (reg_addr == ADDR_CTRL)) en_q <= reg_wdata[CTRL_EN_BIT];
    end

    // Read multiplexer: only implemented bits return nonzero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_DATA:  reg_rdata[FRAME_W-1:0]     = data_q;
            ADDR_EVT:   reg_rdata[EVT_BIT]         = evt_q;
            ADDR_SPEED: reg_rdata[SPD_LO +: DIV_W] = div_q;
            default:    reg_rdata[CTRL_EN_BIT]     = en_q;
        endcase
    end

    // R9: a frame write during a transaction leaves the register alone.
    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_data && busy && !capture_we) |=> $stable(data_q));

    // R8: completion wins over a simultaneous clear.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> evt_q);

    // R10: a disabled controller or zero divider never leaves idle.
    a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_data && !busy && (!en_q || (div_q == '0))) |=> !busy);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Module: top of the management frame controller.
// Connects the register block, the clock generator and the serialiser.
// Assumes a single external tri-state buffer driven by mdio_o/mdio_oe.
module mdio_mgmt_ctrl #(
    parameter int PRE_LEN = 32,
    parameter int DIV_W   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic        busy,
    output logic        irq
);
    import mdio_pkg::*;

    logic               start;
    logic [FRAME_W-1:0] frame;
    logic [DIV_W-1:0]   div;
    logic               rise_tick;
    logic               fall_tick;
    logic               done;
    logic               capture_we;
    logic [RX_W-1:0]    rx_data;

    mdio_regs #(.FRAME_W(FRAME_W), .DIV_W(DIV_W), .RX_W(RX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .done(done), .capture_we(capture_we), .rx_data(rx_data),
        .start(start), .frame(frame), .div(div), .irq(irq)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .start(start), .run(busy), .div_in(div),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_shifter #(.PRE_LEN(PRE_LEN), .FRAME_W(FRAME_W), .RX_W(RX_W), .TA_W(TA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .run(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
        .capture_we(capture_we), .rx_data(rx_data)
    );

    // R2: an accepted start is visible as busy in the next cycle.
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R7: busy only drops with the completion event raised.
    a_r7_busy_event: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);
endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
    import mdio_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i, busy, irq;

    int checks = 0;
    int errors = 0;
    int bit_cnt = 64;
    int hi_cnt = 0;
    int lo_cnt = 0;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;
    logic [15:0] resp = '0;

    mdio_mgmt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .busy(busy), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Simple PHY responder: presents reply bits during the 16 data slots.
    assign mdio_i = (bit_cnt >= 48 && bit_cnt < 64) ? resp[4'(63 - bit_cnt)] : 1'b1;

    // Wire monitor: records line value and enable at every rising mdc.
    always @(posedge mdc) begin
        if (bit_cnt < 64) begin
            cap_o[6'(63 - bit_cnt)]  = mdio_o;
            cap_oe[6'(63 - bit_cnt)] = mdio_oe;
        end
        bit_cnt++;
    end

    // Count high and low mdc cycles while a transaction runs.
    always @(negedge clk) begin
        if (busy) begin
            if (mdc) hi_cnt++;
            else     lo_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_frame(input logic rdop, input logic [4:0] ph,
                                             input logic [4:0] rg, input logic [15:0] val);
        return rdop ? {4'h6, ph, rg, 2'b10, 16'h0000} : {4'h5, ph, rg, 2'b10, val};
    endfunction

    function automatic logic [63:0] exp_oe(input logic rdop);
        return rdop ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_data(input logic rdop, input logic [31:0] f, input logic [15:0] r);
        return rdop ? {f[31:16], r} : f;
    endfunction

    task automatic wait_idle();
        for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
    endtask

    // One complete transaction with all end-of-frame checks.
    task automatic do_frame(input logic [5:0] dv, input logic rdop, input logic [4:0] ph,
                            input logic [4:0] rg, input logic [15:0] val, input logic [15:0] rsp);
        logic [31:0] f, d;
        f = mk_frame(rdop, ph, rg, val);
        reg_write(ADDR_SPEED, {25'b0, dv, 1'b0});
        resp = rsp; bit_cnt = 0; hi_cnt = 0; lo_cnt = 0;
        reg_write(ADDR_DATA, f);
        check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        wait_idle();
        check(!busy && irq, "R7 event with busy low", {busy, irq}, 64'd1);
        check(bit_cnt == 64, "R3 slot count", 64'(bit_cnt), 64'd64);
        check(cap_o == {32'hFFFF_FFFF, f}, "R3 wire bits", cap_o, {32'hFFFF_FFFF, f});
        check(cap_oe == exp_oe(rdop), rdop ? "R5 release" : "R6 driven", cap_oe, exp_oe(rdop));
        check(hi_cnt == 64*dv && lo_cnt == 64*dv, "R4 mdc half-periods",
              {32'(hi_cnt), 32'(lo_cnt)}, {32'(64*dv), 32'(64*dv)});
        reg_read(ADDR_DATA, d);
        check(d == exp_data(rdop, f, rsp), rdop ? "R5 read data" : "R6 data kept", d, exp_data(rdop, f, rsp));
        reg_read(ADDR_EVT, d);
        check(d == 32'h0080_0000, "R7 event bit 23", d, 32'h0080_0000);
        reg_write(ADDR_EVT, 32'hFF7F_FFFF);
        reg_read(ADDR_EVT, d);
        check(d == 32'h0080_0000, "R8 write zero keeps", d, 32'h0080_0000);
        reg_write(ADDR_EVT, 32'h0080_0000);
        reg_read(ADDR_EVT, d);
        check(d == 32'h0 && !irq, "R8 write one clears", {irq, d}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual %0d expected 0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, fa, fb;
        int seed;
        seed = int'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(!mdc && !mdio_oe && !busy && !irq, "R1 outputs", {mdc, mdio_oe, busy, irq}, 64'd0);
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), d);
            check(d == 32'h0, "R1 register zero", d, 32'h0);
        end

        // R11: implemented bits only
        reg_write(ADDR_SPEED, 32'hFFFF_FFFF);
        reg_read(ADDR_SPEED, d);
        check(d == 32'h0000_007E, "R11 speed bits", d, 32'h7E);
        reg_write(ADDR_CTRL, 32'hFFFF_FFFF);
        reg_read(ADDR_CTRL, d);
        check(d == 32'h0000_0004, "R11 control bit", d, 32'h4);
        reg_write(ADDR_EVT, 32'hFFFF_FFFF);
        reg_read(ADDR_EVT, d);
        check(d == 32'h0, "R11 event not settable", d, 32'h0);

        // R10: enable clear, divider nonzero
        reg_write(ADDR_CTRL, 32'h0);
        reg_write(ADDR_SPEED, 32'h4);
        reg_write(ADDR_DATA, 32'h5A5A_1234);
        repeat (10) @(negedge clk);
        check(!busy && !mdc, "R10 disabled no start", {busy, mdc}, 64'd0);
        reg_read(ADDR_DATA, d);
        check(d == 32'h5A5A_1234, "R10 value stored", d, 32'h5A5A_1234);
        // R10: enabled, divider zero
        reg_write(ADDR_CTRL, 32'h4);
        reg_write(ADDR_SPEED, 32'h0);
        reg_write(ADDR_DATA, 32'h6000_0000);
        repeat (10) @(negedge clk);
        check(!busy && !mdc && !irq, "R10 zero divider no start", {busy, mdc, irq}, 64'd0);

        // Directed corners
        do_frame(6'd1, 1'b0, 5'd1, 5'd0, 16'hFFFF, 16'h0000);
        do_frame(6'd1, 1'b1, 5'd31, 5'd31, 16'h0000, 16'hFFFF);
        do_frame(6'd2, 1'b1, 5'd0, 5'd1, 16'h0000, 16'h0000);
        do_frame(6'd63, 1'b1, 5'd5, 5'd2, 16'h0000, 16'hA5C3);

        // R9: frame write during a transaction is ignored
        fa = mk_frame(1'b0, 5'd3, 5'd4, 16'hBEEF);
        fb = mk_frame(1'b1, 5'd9, 5'd9, 16'h0000);
        reg_write(ADDR_SPEED, 32'h4);
        bit_cnt = 0; resp = 16'h1111;
        reg_write(ADDR_DATA, fa);
        repeat (30) @(negedge clk);
        reg_write(ADDR_DATA, fb);
        reg_read(ADDR_DATA, d);
        check(d == fa, "R9 readback unchanged", d, fa);
        wait_idle();
        check(cap_o == {32'hFFFF_FFFF, fa}, "R9 wire unchanged", cap_o, {32'hFFFF_FFFF, fa});
        reg_read(ADDR_DATA, d);
        check(d == fa, "R9 register after frame", d, fa);
        reg_write(ADDR_EVT, 32'h0080_0000);

        // Random transactions
        for (int i = 0; i < 10; i++) begin
            do_frame(6'(1 + $urandom % 4), 1'($urandom), 5'($urandom), 5'($urandom),
                     16'($urandom), 16'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule